// File: doc/BRIEF.md
# Multiplexed Address/Data External Bus Port

This block turns two 8-bit port pin groups into an external memory bus when the chip runs in expanded mode. The high byte of every bus address goes out on a dedicated high port for the whole bus cycle. The second port is shared. It carries the low address byte while the E clock is low, and it carries data while E is high. On writes it drives that data out. On reads it releases the pins and the block captures the data.

A bus cycle is four internal clocks long. The block generates the E clock and an address strobe that marks when the low address is valid. It also generates the output enables for both pin groups, the read/write line and the captured read data.

A request (address, direction, write data, valid) is latched at each cycle boundary. Addresses inside the on-chip register window are served internally. The one exception is the high-port register offset: in expanded mode that port has become the address bus, so accesses to its offset are routed to the external bus instead. In single-chip mode neither pin group is driven.

Top module: `xbus_port`

## Requirements
- R1: E is low for phases 0 and 1 and high for phases 2 and 3 of every four-clock bus cycle, in every mode.
- R2: The address strobe is high only in phase 1, and only in expanded mode.
- R3: In expanded mode the high port output enable is always 1. The high port carries bits 15..8 of the current cycle's address.
- R4: In an active expanded-mode cycle, the shared port drives address bits 7..0 in phase 1, and in phase 0 too unless R7 applies.
- R5: In an external write cycle, while E is high, the shared port drives the write data, its enable is 1 and the read/write line is 0.
- R6: In an external read cycle, while E is high, the shared port is not driven and the read/write line is 1. The pin value is captured when E falls. It is presented on the read-data output, with a one-clock valid pulse, in phase 0 of the next cycle.
- R7: In the phase 0 that follows an external read cycle, the shared port is not driven, even when the new cycle is active.
- R8: Decode is done on the latched address. Addresses 0x1000..0x103F form the register window, and 0x1004 is the high-port register offset. In expanded mode, 0x1004 and every address outside the window is external (ext select = 1, register select = 0). Other window addresses select the register (register select = 1), get no data phase, and leave the read/write line at 1.
- R9: In single-chip mode neither port is driven and no cycle is external. An access to 0x1004 selects the register.
- R10: A request is latched only at the end of phase 3. Changing the request inputs in the middle of a cycle does not change that cycle's outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock, four per bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| expanded | input | 1 | 1 = expanded bus mode, 0 = single-chip |
| cpu_go | input | 1 | A request is present for the next bus cycle |
| cpu_addr | input | 16 | Request address |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 8 | Write data |
| e_clk | output | 1 | E clock |
| as_strobe | output | 1 | Address strobe |
| rw_n | output | 1 | Read/write line, 0 on external writes |
| hi_port_o | output | 8 | High address byte pins |
| hi_port_oe | output | 1 | High port output enable |
| mux_o | output | 8 | Shared port output value |
| mux_oe | output | 1 | Shared port output enable |
| mux_i | input | 8 | Shared port pin value |
| rd_data | output | 8 | Captured read data |
| rd_valid | output | 1 | One-clock pulse when rd_data is new |
| reg_sel | output | 1 | Current cycle targets an on-chip register |
| ext_sel | output | 1 | Current cycle goes to the external bus |

## Verification
The bench uses the default parameters: a 16-bit address, 8-bit data, a 64-byte register window at 0x1000, and the high-port register at offset 4. With these values both edges of the register window can be reached, as well as the rerouted offset in both directions and both modes. A back-to-back read then write exercises the turnaround gap. Because mid-cycle input changes are applied, a design that latches requests at the wrong moment is exposed.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int PH_W = 2;
  typedef enum logic [PH_W-1:0] {
    PH_ADDR0 = 2'd0,
    PH_ADDR1 = 2'd1,
    PH_DATA0 = 2'd2,
    PH_DATA1 = 2'd3
  } bus_ph_e;
endpackage

// File: rtl/xbus_phase_gen.sv
module xbus_phase_gen
  import xbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    expanded,
  output bus_ph_e ph,
  output logic    e_clk,
  output logic    as_strobe,
  output logic    cyc_end
);
  bus_ph_e ph_q, ph_d;

  always_comb begin
    ph_d = bus_ph_e'(ph_q + 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_ADDR0;
    else        ph_q <= ph_d;
  end

  assign ph        = ph_q;
  assign e_clk     = (ph_q == PH_DATA0) || (ph_q == PH_DATA1);
  assign as_strobe = expanded && (ph_q == PH_ADDR1);
  assign cyc_end   = (ph_q == PH_DATA1);

  // R1: E stays high for exactly two clocks
  a_r1_e_two_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(e_clk) |=> (e_clk && !as_strobe));
  // R1: E stays low for exactly two clocks
  a_r1_e_two_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(e_clk) |=> (!e_clk));
  // R2: strobe is immediately followed by E rising
  a_r2_as_then_e: assert property (@(posedge clk) disable iff (!rst_n)
    as_strobe |=> $rose(e_clk));
endmodule

// File: rtl/xbus_decode.sv
module xbus_decode #(
  parameter int          ADDR_W        = 16,
  parameter int          SPAN_LOG2     = 6,
  parameter logic [15:0] REG_BASE      = 16'h1000,
  parameter int          HIPORT_OFS    = 4
) (
  input  logic              expanded,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr,
  output logic              reg_sel,
  output logic              ext_sel
);
  localparam int WIN_W = ADDR_W - SPAN_LOG2;
  localparam logic [WIN_W-1:0]     WIN_TAG = REG_BASE[ADDR_W-1:SPAN_LOG2];
  localparam logic [SPAN_LOG2-1:0] HP_OFS  = SPAN_LOG2'(HIPORT_OFS);

  logic in_win, hp_hit, keep_int;

  always_comb begin
    in_win   = (addr[ADDR_W-1:SPAN_LOG2] == WIN_TAG);
    hp_hit   = in_win && (addr[SPAN_LOG2-1:0] == HP_OFS);
    keep_int = in_win && !(expanded && hp_hit);
    reg_sel  = go && keep_int;
    ext_sel  = go && expanded && !keep_int;
  end
endmodule

// File: rtl/xbus_datapath.sv
module xbus_datapath
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expanded,
  input  bus_ph_e           ph,
  input  logic              e_clk,
  input  logic              cyc_end,
  input  logic              cpu_go,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              ext_sel,
  output logic              q_go,
  output logic [ADDR_W-1:0] q_addr,
  output logic              rw_n,
  output logic [ADDR_W-DATA_W-1:0] hi_port_o,
  output logic              hi_port_oe,
  output logic [DATA_W-1:0] mux_o,
  output logic              mux_oe,
  input  logic [DATA_W-1:0] mux_i,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic              q_wr, q_wr_d, q_go_d, last_rd, last_rd_d, rdv_d;
  logic [ADDR_W-1:0] q_addr_d;
  logic [DATA_W-1:0] q_wdata, q_wdata_d, rd_data_d;
  logic              ext_rd, ext_wr;

  always_comb begin
    ext_rd = ext_sel && !q_wr;
    ext_wr = ext_sel && q_wr;
    q_go_d    = cyc_end ? cpu_go    : q_go;
    q_addr_d  = cyc_end ? cpu_addr  : q_addr;
    q_wr_d    = cyc_end ? cpu_wr    : q_wr;
    q_wdata_d = cyc_end ? cpu_wdata : q_wdata;
    last_rd_d = cyc_end ? ext_rd    : last_rd;
    rd_data_d = (cyc_end && ext_rd) ? mux_i : rd_data;
    rdv_d     = cyc_end && ext_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_go     <= 1'b0;
      q_addr   <= '0;
      q_wr     <= 1'b0;
      q_wdata  <= '0;
      last_rd  <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      q_go     <= q_go_d;
      q_addr   <= q_addr_d;
      q_wr     <= q_wr_d;
      q_wdata  <= q_wdata_d;
      last_rd  <= last_rd_d;
      rd_data  <= rd_data_d;
      rd_valid <= rdv_d;
    end
  end

  always_comb begin
    hi_port_oe = expanded;
    hi_port_o  = q_addr[ADDR_W-1:DATA_W];
    rw_n       = !ext_wr;
    mux_o      = e_clk ? q_wdata : q_addr[DATA_W-1:0];
    unique case (ph)
      PH_ADDR0: mux_oe = expanded && q_go && !last_rd;
      PH_ADDR1: mux_oe = expanded && q_go;
      default:  mux_oe = ext_wr;
    endcase
  end

  // R5: external write drives data with write direction during E high
  a_r5_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (e_clk && ext_wr) |-> (mux_oe && !rw_n && mux_o == q_wdata));
  // R6: external read releases the shared port while E is high
  a_r6_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    (e_clk && ext_rd) |-> (!mux_oe && rw_n));
  // R6: read-data valid is a single-clock pulse
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  // R7: turnaround gap after an external read
  a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && ext_rd) |=> !mux_oe);
  // R9: no pin driving in single-chip mode
  a_r9_single_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !expanded |-> (!mux_oe && !hi_port_oe));
  // R10: latched address holds through the cycle
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_ADDR0) |-> $stable(q_addr));
endmodule

// File: rtl/xbus_port.sv
module xbus_port
  import xbus_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 8,
  parameter int          SPAN_LOG2  = 6,
  parameter logic [15:0] REG_BASE   = 16'h1000,
  parameter int          HIPORT_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expanded,
  input  logic              cpu_go,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              e_clk,
  output logic              as_strobe,
  output logic              rw_n,
  output logic [ADDR_W-DATA_W-1:0] hi_port_o,
  output logic              hi_port_oe,
  output logic [DATA_W-1:0] mux_o,
  output logic              mux_oe,
  input  logic [DATA_W-1:0] mux_i,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              reg_sel,
  output logic              ext_sel
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  bus_ph_e           ph;
  logic              cyc_end, q_go;
  logic [ADDR_W-1:0] q_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  xbus_phase_gen u_phase (
    .clk(clk), .rst_n(rst_sync_n), .expanded(expanded), .ph(ph),
    .e_clk(e_clk), .as_strobe(as_strobe), .cyc_end(cyc_end)
  );

  xbus_decode #(
    .ADDR_W(ADDR_W), .SPAN_LOG2(SPAN_LOG2), .REG_BASE(REG_BASE),
    .HIPORT_OFS(HIPORT_OFS)
  ) u_dec (
    .expanded(expanded), .go(q_go), .addr(q_addr),
    .reg_sel(reg_sel), .ext_sel(ext_sel)
  );

  xbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_sync_n), .expanded(expanded), .ph(ph),
    .e_clk(e_clk), .cyc_end(cyc_end), .cpu_go(cpu_go), .cpu_addr(cpu_addr),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .ext_sel(ext_sel),
    .q_go(q_go), .q_addr(q_addr), .rw_n(rw_n), .hi_port_o(hi_port_o),
    .hi_port_oe(hi_port_oe), .mux_o(mux_o), .mux_oe(mux_oe), .mux_i(mux_i),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // R8: register and external selects never both active
  a_r8_sel_exclusive: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(reg_sel && ext_sel));
endmodule

// File: tb/sim_xbus_port.sv
module sim_xbus_port;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {addr[15:0], wr, wdata[7:0], pin value[7:0]}
  localparam logic [32:0] VEC [NV] = '{
    {16'h8034, 1'b1, 8'hA5, 8'h00},
    {16'hC1F0, 1'b0, 8'h00, 8'h3C},
    {16'h1004, 1'b0, 8'h00, 8'h96},
    {16'h1004, 1'b1, 8'h5A, 8'h00},
    {16'h1010, 1'b1, 8'h77, 8'h00},
    {16'h103F, 1'b0, 8'h00, 8'hC3},
    {16'hFFFF, 1'b0, 8'h00, 8'hFF},
    {16'h0000, 1'b1, 8'h00, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0, expanded = 1'b1, cpu_go = 1'b0, cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0, mux_i = '0;
  logic e_clk, as_strobe, rw_n, hi_port_oe, mux_oe, rd_valid, reg_sel, ext_sel;
  logic [7:0] hi_port_o, mux_o, rd_data;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_port u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sync_ph1();
    do @(negedge clk); while (!e_clk);
    do @(negedge clk); while (e_clk);
    @(negedge clk);
  endtask

  function automatic bit is_reg(input logic [15:0] a, input bit exp_mode);
    return (a[15:6] == 10'h040) && !(exp_mode && a[5:0] == 6'd4);
  endfunction

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    // reset state
    chk(mux_oe == 0, "R4 reset mux_oe", 16'(mux_oe), 0);
    chk(rd_valid == 0 && rw_n == 1, "R6 reset rd_valid/rw_n", {rd_valid, rw_n}, 16'h1);
    chk(e_clk == 0, "R1 reset e_clk", 16'(e_clk), 0);
    chk(hi_port_oe == 1, "R3 reset hi_oe", 16'(hi_port_oe), 1);
    rst_n = 1'b1;
    sync_ph1();
    for (int v = 0; v < NV; v++) begin
      logic [15:0] a; logic w; logic [7:0] wd, pin; bit ext;
      {a, w, wd, pin} = VEC[v];
      ext = !is_reg(a, 1'b1);
      cpu_addr = a; cpu_wr = w; cpu_wdata = wd; cpu_go = 1'b1;
      step(4);                                   // next cycle, phase 1
      chk(as_strobe && !e_clk, "R2 strobe in phase 1", {as_strobe, e_clk}, 16'h2);
      chk(hi_port_o == a[15:8] && hi_port_oe, "R3 high address", hi_port_o, a[15:8]);
      chk(mux_oe && mux_o == a[7:0], "R4 low address", mux_o, a[7:0]);
      chk(ext_sel == ext && reg_sel == !ext, "R8 decode", {ext_sel, reg_sel}, {ext, !ext});
      cpu_addr = 16'h5555; cpu_go = 1'b0; cpu_wr = ~w; cpu_wdata = 8'hEE;
      mux_i = pin;
      step(1);                                   // phase 2
      chk(e_clk && !as_strobe, "R1 E high phase 2", {e_clk, as_strobe}, 16'h2);
      chk(hi_port_o == a[15:8], "R10 mid-cycle change ignored", hi_port_o, a[15:8]);
      chk(rw_n == !(ext && w), "R5 rw_n", 16'(rw_n), 16'(!(ext && w)));
      chk(mux_oe == (ext && w), "R6 data drive", 16'(mux_oe), 16'(ext && w));
      if (ext && w) chk(mux_o == wd, "R5 write data", mux_o, wd);
      step(1);                                   // phase 3
      chk(e_clk, "R1 E high phase 3", 16'(e_clk), 1);
      step(1);                                   // following phase 0
      chk(!e_clk && rd_valid == (ext && !w), "R6 rd_valid", 16'(rd_valid), 16'(ext && !w));
      if (ext && !w) chk(rd_data == pin, "R6 captured data", rd_data, pin);
      chk(!mux_oe, "R7 idle phase 0", 16'(mux_oe), 0);
      step(1);
    end
    // R7: read directly followed by write
    cpu_addr = 16'h9000; cpu_wr = 0; cpu_go = 1;
    step(4);
    cpu_addr = 16'h9001; cpu_wr = 1; cpu_wdata = 8'h11;
    step(3);
    chk(!mux_oe, "R7 turnaround after read", 16'(mux_oe), 0);
    step(1);
    chk(mux_oe && mux_o == 8'h01, "R4 address after turnaround", mux_o, 16'h01);
    cpu_addr = 16'h9002;
    step(3);
    chk(mux_oe && mux_o == 8'h02, "R4 phase 0 drive after write", {7'd0, mux_oe, mux_o}, 16'h0102);
    cpu_go = 0;
    step(1);
    // R9: single-chip mode
    step(4);
    expanded = 0; cpu_addr = 16'h1004; cpu_wr = 0; cpu_go = 1;
    step(4);
    chk(!mux_oe && !hi_port_oe && !as_strobe, "R9 no drive", {mux_oe, hi_port_oe, as_strobe}, 0);
    chk(reg_sel && !ext_sel, "R9 high-port offset internal", {reg_sel, ext_sel}, 16'h2);
    step(1);
    chk(e_clk && !mux_oe, "R1 E runs in single-chip", {e_clk, mux_oe}, 16'h2);
    step(2);
    chk(!rd_valid, "R9 no capture", 16'(rd_valid), 0);
    cpu_go = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule